// File: doc/BRIEF.md
# Interrupt Controller Programming Port

This block is the byte-wide register front end of one interrupt controller core. Software talks to it through a one-bit address, a write strobe and a read strobe. A write to address 0 carries either an initialization start or an operation command. A write to address 1 carries the next word of the initialization sequence, or a new interrupt mask when no sequence is running. The block holds the mask, the vector base, the rotation base and the mode flags. It presents them to the priority core as steady outputs.

End-of-interrupt commands leave the block as a one-cycle pulse that carries the line whose in-service bit the core must clear. An initialization start leaves as a one-cycle clear pulse. The core uses that pulse to empty its request and in-service registers and to drop its interrupt output. For the non-specific forms, the block finds the highest-priority in-service line itself, using the rotated priority order. The core supplies its request and in-service registers and its current poll winner as inputs. Read data is registered and appears one cycle after the read strobe.

Top module: `icu_prog_port`

## Requirements
- R1: After reset, the mask, vector base, rotation base and every mode flag are 0. The read data is 0 and no pulse output is high.
- R2: An address-0 write with bit 4 = 1 starts initialization. On the next cycle init_clr_o pulses, and the mask, vector base, rotation base, poll flag, read select and all mode flags are 0. Bit 0 of the word records whether a fourth word will follow.
- R3: The first address-1 write after an initialization start sets the vector base to the data with bits 2:0 forced to 0. The mask is left alone.
- R4: The second address-1 write (the cascade word) changes no output. If no fourth word was requested, initialization ends there, and the next address-1 write loads the mask.
- R5: When a fourth word was requested, the third address-1 write sets the nested flag from bit 4 and the auto-EOI flag from bit 1. Initialization then ends.
- R6: Outside initialization, an address-1 write loads the mask. An address-1 read returns the mask.
- R7: An address-0 write with bit 4 = 0 and bit 3 = 1 sets poll mode when bit 2 = 1. When bit 1 = 1, it sets the read select from bit 0 (1 = in-service, 0 = request). When bit 6 = 1, it sets the special-mask flag from bit 5.
- R8: Other address-0 writes decode bits 7:5. Codes 0 and 4 set the rotate-on-auto-EOI flag to bit 7. Code 2 changes nothing.
- R9: Code 1 (non-specific EOI) pulses eoi_vld_o with the highest-priority set bit of svc_i. Priority starts at the rotation base and wraps upward through 7 to 0. If svc_i is 0, nothing is pulsed.
- R10: Code 5 acts like code 1. When a line is found, it also sets the rotation base to that line + 1 mod 8.
- R11: Code 3 pulses eoi_vld_o for line data[2:0], whatever svc_i holds. Code 7 does the same and sets the rotation base to data[2:0] + 1 mod 8.
- R12: Code 6 sets the rotation base to data[2:0] + 1 mod 8 and pulses no EOI.
- R13: Without poll mode, a read loads rdata_o on the clock edge of the strobe. Address 0 returns svc_i or req_i according to the read select, and address 1 returns the mask. rdata_o holds that value until the next read.
- R14: In poll mode, a read at either address clears poll mode. If poll_hit_i = 1, the read returns poll_line_i in bits 2:0 with the upper bits 0, and poll_ack_o pulses with that line. Otherwise the read returns 7 and no acknowledge pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_i | input | 1 | Single-cycle write strobe |
| rd_i | input | 1 | Single-cycle read strobe |
| a0_i | input | 1 | Register address bit |
| wdata_i | input | 8 | Write data |
| req_i | input | 8 | Request register from the core |
| svc_i | input | 8 | In-service register from the core |
| poll_hit_i | input | 1 | Core has a winning request for a poll |
| poll_line_i | input | 3 | Line that wins the poll |
| rdata_o | output | 8 | Registered read data |
| mask_o | output | 8 | Interrupt mask |
| vec_base_o | output | 8 | Vector base, low three bits 0 |
| rot_base_o | output | 3 | Lowest-numbered priority position (rotation base) |
| auto_eoi_o | output | 1 | Automatic end-of-interrupt mode |
| rot_aeoi_o | output | 1 | Rotate on automatic end-of-interrupt |
| nested_o | output | 1 | Special fully nested mode |
| spec_mask_o | output | 1 | Special mask mode |
| init_clr_o | output | 1 | Pulse: clear request and in-service, drop output |
| eoi_vld_o | output | 1 | Pulse: clear the in-service bit of eoi_line_o |
| eoi_line_o | output | 3 | Line to clear |
| poll_ack_o | output | 1 | Pulse: polled line is taken |
| poll_ack_line_o | output | 3 | Line taken by the poll |

## Verification
Some properties are checked on every cycle. An initialization start must produce the clear pulse with the mask and rotation base zeroed. A non-specific EOI with an empty in-service input must never pulse. The mask must stay steady when there is no write, and any read must leave poll mode off. The vector base stored from the first sequence word must equal the written byte with its low bits dropped.

Other behaviour needs the bench's scenarios. These are the rotated search order across successive commands, the running rotation base after rotating EOIs and code 6, the step-by-step sequence with and without the fourth word, the read-select and special-mask enable bits, and the poll result with and without a winner.

// File: rtl/icu_prog_pkg.sv
package icu_prog_pkg;

    // position in the initialization word sequence
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_VEC  = 2'd1,
        SEQ_CASC = 2'd2,
        SEQ_MODE = 2'd3
    } seq_e;

    // decoded meaning of an address-0 write
    typedef enum logic [3:0] {
        CMD_NOP        = 4'd0,
        CMD_INIT       = 4'd1,
        CMD_RDCTL      = 4'd2,
        CMD_SET_RAEOI  = 4'd3,
        CMD_NS_EOI     = 4'd4,
        CMD_NS_EOI_ROT = 4'd5,
        CMD_SP_EOI     = 4'd6,
        CMD_SP_EOI_ROT = 4'd7,
        CMD_SET_ROT    = 4'd8
    } cmd_e;

endpackage

// File: rtl/icu_cmd_dec.sv
module icu_cmd_dec
    import icu_prog_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] word_i,
    output cmd_e              cmd_o
);

    // bit positions are fixed by the command word format
    always_comb begin
        if (word_i[4]) begin
            cmd_o = CMD_INIT;
        end else if (word_i[3]) begin
            cmd_o = CMD_RDCTL;
        end else begin
            case (word_i[7:5])
                3'd0, 3'd4: cmd_o = CMD_SET_RAEOI;
                3'd1:       cmd_o = CMD_NS_EOI;
                3'd5:       cmd_o = CMD_NS_EOI_ROT;
                3'd3:       cmd_o = CMD_SP_EOI;
                3'd7:       cmd_o = CMD_SP_EOI_ROT;
                3'd6:       cmd_o = CMD_SET_ROT;
                default:    cmd_o = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/icu_rot_prio.sv
module icu_rot_prio #(
    parameter int LINE_W = 3,
    localparam int NLINES = 1 << LINE_W
) (
    input  logic [NLINES-1:0] vec_i,
    input  logic [LINE_W-1:0] base_i,
    output logic              found_o,
    output logic [LINE_W-1:0] line_o
);

    logic [LINE_W-1:0] idx;

    // walk from the lowest priority position down so the first hit at or above base wins
    always_comb begin
        found_o = 1'b0;
        line_o  = '0;
        idx     = '0;
        for (int i = NLINES - 1; i >= 0; i--) begin
            idx = base_i + LINE_W'(i);
            if (vec_i[idx]) begin
                found_o = 1'b1;
                line_o  = idx;
            end
        end
    end

    // R9
    always_comb begin
        found_vs_any_chk: assert (found_o == (|vec_i));
    end

endmodule

// File: rtl/icu_prog_port.sv
module icu_prog_port
    import icu_prog_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LINE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic              a0_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [7:0]        req_i,
    input  logic [7:0]        svc_i,
    input  logic              poll_hit_i,
    input  logic [LINE_W-1:0] poll_line_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [7:0]        mask_o,
    output logic [DATA_W-1:0] vec_base_o,
    output logic [LINE_W-1:0] rot_base_o,
    output logic              auto_eoi_o,
    output logic              rot_aeoi_o,
    output logic              nested_o,
    output logic              spec_mask_o,
    output logic              init_clr_o,
    output logic              eoi_vld_o,
    output logic [LINE_W-1:0] eoi_line_o,
    output logic              poll_ack_o,
    output logic [LINE_W-1:0] poll_ack_line_o
);

    localparam int NLINES = 1 << LINE_W;
    localparam logic [DATA_W-1:0] NO_POLL = DATA_W'(NLINES - 1);

    typedef struct packed {
        seq_e              seq;
        logic              need4;
        logic [NLINES-1:0] mask;
        logic [DATA_W-1:0] vbase;
        logic [LINE_W-1:0] rot;
        logic              aeoi;
        logic              raeoi;
        logic              nest;
        logic              smm;
        logic              poll;
        logic              rsel_isr;
        logic [DATA_W-1:0] rdata;
        logic              init_clr;
        logic              eoi_vld;
        logic [LINE_W-1:0] eoi_line;
        logic              pack;
        logic [LINE_W-1:0] pline;
    } st_t;

    st_t               st_q;
    st_t               st_d;
    cmd_e              cmd;
    logic              hi_found;
    logic [LINE_W-1:0] hi_line;

    icu_cmd_dec #(.DATA_W(DATA_W)) dec_i (
        .word_i (wdata_i),
        .cmd_o  (cmd)
    );

    icu_rot_prio #(.LINE_W(LINE_W)) prio_i (
        .vec_i   (svc_i[NLINES-1:0]),
        .base_i  (st_q.rot),
        .found_o (hi_found),
        .line_o  (hi_line)
    );

    always_comb begin
        st_d          = st_q;
        st_d.init_clr = 1'b0;
        st_d.eoi_vld  = 1'b0;
        st_d.pack     = 1'b0;

        // read path uses the state before any write in the same cycle
        if (rd_i) begin
            if (st_q.poll) begin
                st_d.poll = 1'b0;
                if (poll_hit_i) begin
                    st_d.rdata = DATA_W'(poll_line_i);
                    st_d.pack  = 1'b1;
                    st_d.pline = poll_line_i;
                end else begin
                    st_d.rdata = NO_POLL;
                end
            end else if (!a0_i) begin
                st_d.rdata = st_q.rsel_isr ? DATA_W'(svc_i) : DATA_W'(req_i);
            end else begin
                st_d.rdata = DATA_W'(st_q.mask);
            end
        end

        if (wr_i && !a0_i) begin
            case (cmd)
                CMD_INIT: begin
                    st_d.seq      = SEQ_VEC;
                    st_d.need4    = wdata_i[0];
                    st_d.mask     = '0;
                    st_d.vbase    = '0;
                    st_d.rot      = '0;
                    st_d.aeoi     = 1'b0;
                    st_d.raeoi    = 1'b0;
                    st_d.nest     = 1'b0;
                    st_d.smm      = 1'b0;
                    st_d.poll     = 1'b0;
                    st_d.rsel_isr = 1'b0;
                    st_d.init_clr = 1'b1;
                end
                CMD_RDCTL: begin
                    if (wdata_i[2]) st_d.poll = 1'b1;
                    if (wdata_i[1]) st_d.rsel_isr = wdata_i[0];
                    if (wdata_i[6]) st_d.smm = wdata_i[5];
                end
                CMD_SET_RAEOI: st_d.raeoi = wdata_i[7];
                CMD_NS_EOI, CMD_NS_EOI_ROT: begin
                    if (hi_found) begin
                        st_d.eoi_vld  = 1'b1;
                        st_d.eoi_line = hi_line;
                        if (cmd == CMD_NS_EOI_ROT) st_d.rot = hi_line + 1'b1;
                    end
                end
                CMD_SP_EOI, CMD_SP_EOI_ROT: begin
                    st_d.eoi_vld  = 1'b1;
                    st_d.eoi_line = wdata_i[LINE_W-1:0];
                    if (cmd == CMD_SP_EOI_ROT) st_d.rot = wdata_i[LINE_W-1:0] + 1'b1;
                end
                CMD_SET_ROT: st_d.rot = wdata_i[LINE_W-1:0] + 1'b1;
                default: ;
            endcase
        end else if (wr_i) begin
            case (st_q.seq)
                SEQ_IDLE: st_d.mask = wdata_i[NLINES-1:0];
                SEQ_VEC: begin
                    st_d.vbase = {wdata_i[DATA_W-1:LINE_W], {LINE_W{1'b0}}};
                    st_d.seq   = SEQ_CASC;
                end
                SEQ_CASC: st_d.seq = st_q.need4 ? SEQ_MODE : SEQ_IDLE;
                SEQ_MODE: begin
                    st_d.nest = wdata_i[4];
                    st_d.aeoi = wdata_i[1];
                    st_d.seq  = SEQ_IDLE;
                end
                default: st_d.seq = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o         = st_q.rdata;
    assign mask_o          = st_q.mask;
    assign vec_base_o      = st_q.vbase;
    assign rot_base_o      = st_q.rot;
    assign auto_eoi_o      = st_q.aeoi;
    assign rot_aeoi_o      = st_q.raeoi;
    assign nested_o        = st_q.nest;
    assign spec_mask_o     = st_q.smm;
    assign init_clr_o      = st_q.init_clr;
    assign eoi_vld_o       = st_q.eoi_vld;
    assign eoi_line_o      = st_q.eoi_line;
    assign poll_ack_o      = st_q.pack;
    assign poll_ack_line_o = st_q.pline;

    // R2
    init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !a0_i && wdata_i[4]) |=> (init_clr_o && mask_o == '0 && rot_base_o == '0));

    // R3
    vec_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && a0_i && st_q.seq == SEQ_VEC) |=>
        (vec_base_o[DATA_W-1:LINE_W] == $past(wdata_i[DATA_W-1:LINE_W]) && vec_base_o[LINE_W-1:0] == '0));

    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mask_o));

    // R9
    ns_eoi_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !a0_i && cmd == CMD_NS_EOI && svc_i == '0) |=> !eoi_vld_o);

    // R14
    poll_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !wr_i) |=> !st_q.poll);

    // R14
    poll_ack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_ack_o |-> $past(rd_i));

endmodule

// File: tb/icu_prog_port_tb.sv
module icu_prog_port_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr = 1'b0, rd = 1'b0, a0 = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] req = 8'h33;
    logic [7:0] svc = 8'h44;
    logic       phit = 1'b0;
    logic [2:0] pline = '0;
    logic [7:0] rdata, mask, vbase;
    logic [2:0] rot, eline, aline;
    logic       aeoi, raeoi, nest, smm, iclr, evld, pack;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    icu_prog_port dut_i (
        .clk(clk), .rst_n(rst_n), .wr_i(wr), .rd_i(rd), .a0_i(a0), .wdata_i(wdata),
        .req_i(req), .svc_i(svc), .poll_hit_i(phit), .poll_line_i(pline),
        .rdata_o(rdata), .mask_o(mask), .vec_base_o(vbase), .rot_base_o(rot),
        .auto_eoi_o(aeoi), .rot_aeoi_o(raeoi), .nested_o(nest), .spec_mask_o(smm),
        .init_clr_o(iclr), .eoi_vld_o(evld), .eoi_line_o(eline),
        .poll_ack_o(pack), .poll_ack_line_o(aline)
    );

    // entry: {command byte, svc, expected eoi pulse, expected line, expected rotation base}
    localparam int NTAB = 13;
    localparam logic [22:0] EOI_TAB [NTAB] = '{
        {8'h20, 8'h28, 1'b1, 3'd3, 3'd0},
        {8'h20, 8'h00, 1'b0, 3'd0, 3'd0},
        {8'hA0, 8'h28, 1'b1, 3'd3, 3'd4},
        {8'h20, 8'h28, 1'b1, 3'd5, 3'd4},
        {8'h20, 8'h08, 1'b1, 3'd3, 3'd4},
        {8'h63, 8'h00, 1'b1, 3'd3, 3'd4},
        {8'hE6, 8'h00, 1'b1, 3'd6, 3'd7},
        {8'hC1, 8'hFF, 1'b0, 3'd0, 3'd2},
        {8'hA0, 8'h02, 1'b1, 3'd1, 3'd2},
        {8'h40, 8'hFF, 1'b0, 3'd0, 3'd2},
        {8'hC7, 8'h00, 1'b0, 3'd0, 3'd0},
        {8'hA0, 8'h80, 1'b1, 3'd7, 3'd0},
        {8'hA0, 8'h00, 1'b0, 3'd0, 3'd0}
    };

    task automatic chk(input string req_tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    task automatic wr_word(input logic addr, input logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; a0 = addr; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_word(input logic addr);
        @(negedge clk);
        rd = 1'b1; a0 = addr;
        @(negedge clk);
        rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mask", mask, 0);
        chk("R1 vbase", vbase, 0);
        chk("R1 rot", rot, 0);
        chk("R1 modes", {aeoi, raeoi, nest, smm}, 0);
        chk("R1 rdata", rdata, 0);
        chk("R1 pulses", {iclr, evld, pack}, 0);

        // R9 R10 R11 R12 R8(code 2): table walk
        for (int k = 0; k < NTAB; k++) begin
            svc = EOI_TAB[k][14:7];
            wr_word(1'b0, EOI_TAB[k][22:15]);
            chk("R9-R12 eoi pulse", evld, int'(EOI_TAB[k][6]));
            if (EOI_TAB[k][6]) chk("R9 R10 R11 eoi line", eline, int'(EOI_TAB[k][5:3]));
            chk("R10 R11 R12 rotation", rot, int'(EOI_TAB[k][2:0]));
            @(negedge clk);
            chk("R9 pulse single", evld, 0);
        end
        svc = 8'h44;

        // R6 mask write and readback
        wr_word(1'b1, 8'h5A);
        chk("R6 mask", mask, 8'h5A);
        rd_word(1'b1);
        chk("R6 mask read", rdata, 8'h5A);

        // R13 request read, registered snapshot
        rd_word(1'b0);
        chk("R13 request read", rdata, 8'h33);
        req = 8'h99;
        @(negedge clk);
        chk("R13 rdata holds", rdata, 8'h33);
        req = 8'h33;

        // R7 read select and special mask
        wr_word(1'b0, 8'h0B);
        rd_word(1'b0);
        chk("R7 select in-service", rdata, 8'h44);
        wr_word(1'b0, 8'h09);
        rd_word(1'b0);
        chk("R7 select kept without bit1", rdata, 8'h44);
        wr_word(1'b0, 8'h0A);
        rd_word(1'b0);
        chk("R7 select request", rdata, 8'h33);
        wr_word(1'b0, 8'h68);
        chk("R7 special mask on", smm, 1);
        wr_word(1'b0, 8'h28);
        chk("R7 special mask kept without bit6", smm, 1);
        wr_word(1'b0, 8'h48);
        chk("R7 special mask off", smm, 0);

        // R8 rotate on auto EOI flag
        wr_word(1'b0, 8'h80);
        chk("R8 raeoi set", raeoi, 1);
        wr_word(1'b0, 8'h00);
        chk("R8 raeoi clear", raeoi, 0);

        // R14 poll with and without a winner
        wr_word(1'b0, 8'h0C);
        phit = 1'b1; pline = 3'd5;
        rd_word(1'b1);
        chk("R14 poll data", rdata, 8'h05);
        chk("R14 poll ack", {pack, aline}, {1'b1, 3'd5});
        @(negedge clk);
        chk("R14 ack single", pack, 0);
        rd_word(1'b0);
        chk("R14 poll cleared", rdata, 8'h33);
        wr_word(1'b0, 8'h0C);
        phit = 1'b0;
        rd_word(1'b0);
        chk("R14 no winner", rdata, 8'h07);
        chk("R14 no ack", pack, 0);

        // R2 R3 R4 R5 init with fourth word
        wr_word(1'b1, 8'hFF);
        wr_word(1'b0, 8'hC2);
        wr_word(1'b0, 8'h68);
        wr_word(1'b0, 8'h80);
        wr_word(1'b0, 8'h0B);
        chk("R12 setup rot", rot, 3);
        wr_word(1'b0, 8'h11);
        chk("R2 clear pulse", iclr, 1);
        chk("R2 mask", mask, 0);
        chk("R2 rot", rot, 0);
        chk("R2 modes", {raeoi, smm}, 0);
        rd_word(1'b0);
        chk("R2 read select reset", rdata, 8'h33);
        wr_word(1'b1, 8'h4D);
        chk("R3 vbase", vbase, 8'h48);
        chk("R3 mask untouched", mask, 0);
        wr_word(1'b1, 8'h00);
        chk("R4 cascade no effect", {mask, aeoi, nest}, 0);
        wr_word(1'b1, 8'h12);
        chk("R5 modes", {nest, aeoi}, 2'b11);
        chk("R5 mask untouched", mask, 0);
        wr_word(1'b1, 8'h33);
        chk("R5 sequence ended", mask, 8'h33);

        // R2 R4 init without fourth word
        wr_word(1'b0, 8'h10);
        chk("R2 modes cleared", {nest, aeoi, vbase}, 0);
        wr_word(1'b1, 8'h20);
        chk("R3 vbase2", vbase, 8'h20);
        wr_word(1'b1, 8'h99);
        chk("R4 cascade mask", mask, 0);
        wr_word(1'b1, 8'h0F);
        chk("R4 mask after short init", mask, 8'h0F);
        chk("R4 modes unchanged", {nest, aeoi}, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule